// File: doc/BRIEF.md
# CPU Stop-Clock Power State Controller

This block steps a processor through its clock-throttling power states. Software starts the sequence by reading the power-management control port. If either throttling mode is enabled, the controller asserts an active-low stop-clock request to the CPU and waits. When the CPU answers with a stop-grant bus cycle and full clock stopping is enabled, the controller also turns off the host clock.

A break (wake) event resumes operation. If it arrives while the clock is only throttled, the controller returns straight to normal operation. If it arrives while the clock is stopped, the controller first restarts the host clock and holds the CPU in a startup state. It stays there for one millisecond, counted in system clocks, and only then releases the stop-clock request.

The state code output uses this encoding: 0 = running, 1 = stop-grant, 2 = clock stopped, 3 = CPU startup. The clock generator, the bus decode and the interrupt handling sit outside this block.

Top module: `clkstop_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the state code is 0 (running), the stop-clock request is high and the host-clock enable is 1.
- R2: In the running state, a control-port read with the stop-grant enable or the stop-clock enable set moves the block to state 1 on the next clock edge. In state 1 the request is low and the host-clock enable is 1.
- R3: In the running state, a control-port read with both enables clear has no effect. A stop-grant cycle or a wake event in the running state also has no effect.
- R4: In state 1, a stop-grant cycle with the stop-clock enable set moves the block to state 2. In state 2 the request is low and the host-clock enable is 0. A stop-grant cycle with the stop-clock enable clear leaves the block in state 1.
- R5: In state 1, a wake event returns the block to state 0 on the next edge.
- R6: In state 1, if a wake event and a stop-grant cycle arrive in the same cycle, the wake event wins and the next state is 0.
- R7: In state 2, a wake event moves the block to state 3. In state 3 the host-clock enable is 1 and the request stays low.
- R8: State 3 lasts exactly CLKS_PER_MS clock cycles and then the block returns to state 0. Wake events and port reads during state 3 have no effect.
- R9: In state 2, control-port reads and stop-grant cycles have no effect; only a wake event leaves state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_port_rd_i | input | 1 | One-cycle strobe: read of the power-management control port |
| sg_cycle_i | input | 1 | One-cycle strobe: stop-grant bus cycle seen |
| wake_i | input | 1 | Break (wake) event |
| sg_en_i | input | 1 | Stop-grant mode enable |
| sc_en_i | input | 1 | Stop-clock mode enable |
| stop_req_n_o | output | 1 | Active-low stop-clock request to the CPU |
| hclk_run_o | output | 1 | Host clock run enable |
| state_o | output | 2 | Power state code (0 running, 1 stop-grant, 2 stopped, 3 startup) |

## Verification
The bench targets a wake event that coincides with a stop-grant cycle. A design that gave the stop-grant cycle priority would stop the clock instead of resuming. It also sends a stop-grant cycle while only stop-grant mode is enabled; a design that ignored the stop-clock enable would wrongly cut the host clock. The startup interval is counted cycle by cycle, with stray wakes and reads injected during it, so an off-by-one counter or a startup state that can be cut short shows up as a state code that changes one cycle early or late. Reads and stop-grant cycles sent in the wrong states confirm that a design reacting outside its own state leaves the expected path.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_GRANT = 2'd1,
    PS_HALT  = 2'd2,
    PS_WAKE  = 2'd3
  } pstate_e;
endpackage

// File: rtl/clkstop_delay.sv
// Restart interval counter: loaded on entry to startup, counts down while in it.
module clkstop_delay #(
  parameter int CLKS_PER_MS = 33000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CLKS_PER_MS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (run_i && (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load_i)
      cnt_d = LOAD_VAL;
    else if (run_i && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == '0);

  // R8: the count never exceeds the reload value
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL);

  // R8: a load always restarts the full interval
  p_load_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == LOAD_VAL));
endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
  import clkstop_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    port_rd_i,
  input  logic    sg_cycle_i,
  input  logic    wake_i,
  input  logic    sg_en_i,
  input  logic    sc_en_i,
  input  logic    delay_done_i,
  output pstate_e state_o,
  output logic    delay_load_o
);
  pstate_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_RUN:   if (port_rd_i && (sg_en_i || sc_en_i)) st_d = PS_GRANT;
      PS_GRANT: if (wake_i) st_d = PS_RUN;
                else if (sg_cycle_i && sc_en_i) st_d = PS_HALT;
      PS_HALT:  if (wake_i) st_d = PS_WAKE;
      PS_WAKE:  if (delay_done_i) st_d = PS_RUN;
      default:  st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= PS_RUN;
    else
      st_q <= st_d;
  end

  assign state_o      = st_q;
  assign delay_load_o = (st_q == PS_HALT) && wake_i;

  p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && port_rd_i && (sg_en_i || sc_en_i)) |=> (st_q == PS_GRANT));

  p_no_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && !(port_rd_i && (sg_en_i || sc_en_i))) |=> (st_q == PS_RUN));

  p_grant_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_GRANT && !wake_i && !(sg_cycle_i && sc_en_i)) |=> (st_q == PS_GRANT));

  p_wake_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_GRANT && wake_i) |=> (st_q == PS_RUN));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HALT && !wake_i) |=> (st_q == PS_HALT));

  p_startup_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_WAKE && !delay_done_i) |=> (st_q == PS_WAKE));

  p_startup_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_WAKE && delay_done_i) |=> (st_q == PS_RUN));
endmodule

// File: rtl/clkstop_outdec.sv
module clkstop_outdec
  import clkstop_pkg::*;
(
  input  pstate_e state_i,
  output logic    stop_req_n_o,
  output logic    hclk_run_o
);
  always_comb begin
    stop_req_n_o = (state_i == PS_RUN);
    hclk_run_o   = (state_i != PS_HALT);
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int CLKS_PER_MS = 33000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pm_port_rd_i,
  input  logic       sg_cycle_i,
  input  logic       wake_i,
  input  logic       sg_en_i,
  input  logic       sc_en_i,
  output logic       stop_req_n_o,
  output logic       hclk_run_o,
  output logic [1:0] state_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  pstate_e    state;
  logic       delay_load, delay_done, in_startup;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  clkstop_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .port_rd_i    (pm_port_rd_i),
    .sg_cycle_i   (sg_cycle_i),
    .wake_i       (wake_i),
    .sg_en_i      (sg_en_i),
    .sc_en_i      (sc_en_i),
    .delay_done_i (delay_done),
    .state_o      (state),
    .delay_load_o (delay_load)
  );

  assign in_startup = (state == PS_WAKE);

  clkstop_delay #(.CLKS_PER_MS(CLKS_PER_MS)) u_delay (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (delay_load),
    .run_i  (in_startup),
    .done_o (delay_done)
  );

  clkstop_outdec u_dec (
    .state_i      (state),
    .stop_req_n_o (stop_req_n_o),
    .hclk_run_o   (hclk_run_o)
  );

  assign state_o = state;

  p_run_req_high_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_o == 2'd0) |-> (stop_req_n_o && hclk_run_o));

  p_halt_clk_off_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_o == 2'd2) |-> (!hclk_run_o && !stop_req_n_o));

  p_startup_clk_on_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_o == 2'd3) |-> (hclk_run_o && !stop_req_n_o));

  p_halt_wake_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_o == 2'd2 && wake_i) |=> (state_o == 2'd3));
endmodule

// File: tb/clkstop_ctrl_tb_top.sv
module clkstop_ctrl_tb_top;
  localparam int N = 6;

  typedef struct {
    int    st;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd = 1'b0, sg = 1'b0, wk = 1'b0, sgen = 1'b0, scen = 1'b0;
  logic       req_n, hrun;
  logic [1:0] st;

  int   checks = 0, fails = 0;
  bit   finished = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  clkstop_ctrl #(.CLKS_PER_MS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pm_port_rd_i(rd), .sg_cycle_i(sg),
    .wake_i(wk), .sg_en_i(sgen), .sc_en_i(scen),
    .stop_req_n_o(req_n), .hclk_run_o(hrun), .state_o(st)
  );

  task automatic check_outs(input int es, input string tag);
    logic er, eh;
    er = (es == 0);
    eh = (es != 2);
    checks++;
    if (st !== es[1:0] || req_n !== er || hrun !== eh) begin
      fails++;
      $display("FAIL %s: state=%0d req_n=%0b hclk=%0b expected state=%0d req_n=%0b hclk=%0b",
               tag, st, req_n, hrun, es, er, eh);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the state expected after the edge
  task automatic step(input logic r, input logic g, input logic w,
                      input int es, input string tag);
    @(negedge clk);
    rd = r; sg = g; wk = w;
    q.push_back('{es, tag});
  endtask

  // monitor: sample after each edge, compare against the scoreboard
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check_outs(e.st, e.tag);
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outs(0, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs(0, "R1 after reset");

    // R3: read with both enables clear, stray strobes
    step(1, 0, 0, 0, "R3 read no enable");
    step(0, 1, 0, 0, "R3 sg cycle in run");
    step(0, 0, 1, 0, "R3 wake in run");

    // R2 via stop-grant enable only, then R4 hold without stop-clock enable
    sgen = 1'b1;
    step(1, 0, 0, 1, "R2 read sg enable");
    step(0, 1, 0, 1, "R4 sg cycle without sc enable");
    step(0, 0, 0, 1, "R4 idle in grant");
    step(0, 0, 1, 0, "R5 wake in grant");

    // R2 via stop-clock enable, R6 simultaneous wake and sg cycle
    sgen = 1'b0; scen = 1'b1;
    step(1, 0, 0, 1, "R2 read sc enable");
    step(0, 1, 1, 0, "R6 wake beats sg cycle");

    // full stop and restart
    step(1, 0, 0, 1, "R2 re-enter grant");
    step(0, 1, 0, 2, "R4 enter clock stopped");
    step(1, 0, 0, 2, "R9 read in stopped");
    step(0, 1, 0, 2, "R9 sg cycle in stopped");
    step(0, 0, 1, 3, "R7 wake in stopped");
    for (int i = 1; i < N; i++) begin
      step((i == 2), 0, (i == 1), 3, "R8 startup hold");
    end
    step(0, 0, 0, 0, "R8 startup done");
    step(0, 0, 0, 0, "R8 stays running");

    // second pass with both enables
    sgen = 1'b1;
    step(1, 0, 0, 1, "R2 both enables");
    step(0, 1, 0, 2, "R4 stop again");
    step(0, 0, 1, 3, "R7 wake again");
    for (int i = 1; i < N; i++) step(0, 0, 0, 3, "R8 second startup");
    step(0, 0, 0, 0, "R8 second exit");

    // reset in the middle of a stop
    step(1, 0, 0, 1, "R2 grant before reset");
    step(0, 1, 0, 2, "R4 stop before reset");
    @(negedge clk);
    rd = 0; sg = 0; wk = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_outs(0, "R1 reset from stopped");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs(0, "R1 after second reset");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule